// File: doc/BRIEF.md
# Storage command request sequencer

This block sits between a user request port and a downstream sub-command issuer of a solid-state storage host. After reset it waits for the link to come up. It then issues one initialization sub-command and holds its busy flag high until that sub-command completes. From then on it takes one user command at a time over a request/busy handshake and decodes the 3-bit opcode. It then drives the issuer with one sub-command strobe per step and waits for the issuer's done or error pulse before it moves on.

Write and read requests of any length, counted in 512-byte sectors, are cut into device sub-commands of at most 256 sectors each. Each sub-command waits until the data buffer level allows it: stored data for a write, free space for a read. A read also waits for the buffer to drain to the user before the block goes idle. Identify loads the device capacity and sector-size mode presented by the issuer. Shutdown, and any reported error, park the block in a terminal state with busy held high until reset.

Top module: `stor_cmd_seq`

## Requirements
- R1: While reset is asserted and right after it is released, busy_o is 1, sub_issue_o is 0, capacity_o is 0 and lba_4k_o is 0.
- R2: No sub-command is issued before link_up_i is seen. After link_up_i, a single initialization sub-command with sub_op_o = 3'b111 is issued. busy_o stays 1 until its done pulse. An error pulse on it leaves busy_o at 1 for good.
- R3: A request is taken only while busy_o is 0. busy_o is 1 in the cycle after the request is sampled, and it returns to 0 once the command has completed.
- R4: Opcodes are 000 identify, 001 shutdown, 010 write, 011 read, 100 health log, 110 flush. A request with 101 or 111 is ignored, and busy_o stays 0.
- R5: A write or read of L sectors from address A issues ceil(L/256) sub-commands in order. Sub-command k has sub_addr_o = A + 256k and sub_cnt_o = min(256, L - 256k). Each one is issued only after the previous one reports done.
- R6: A write sub-command is issued only when buf_fill_i (sectors stored) is at least its sub_cnt_o. The write goes idle right after the done of its last sub-command.
- R7: A read sub-command is issued only when buf_free_i is at least its sub_cnt_o. After the done of the last one, busy_o stays 1 until buf_fill_i is 0.
- R8: Identify, shutdown, health log and flush each issue exactly one sub-command that carries the request opcode, sub_addr_o = addr_i and sub_cnt_o = 0.
- R9: When an identify sub-command reports done, capacity_o and lba_4k_o take the values of id_cap_i and id_4k_i (0 = 512 B, 1 = 4 KB). Nothing else changes them.
- R10: After a shutdown sub-command reports done, busy_o stays 1 and no request is taken until reset.
- R11: A write or read with length 0 raises busy_o for one cycle and issues no sub-command.
- R12: An error pulse on any outstanding sub-command leaves busy_o at 1 and blocks further requests until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | Link ready |
| req_i | input | 1 | Command request |
| op_i | input | 3 | Command opcode |
| addr_i | input | 48 | Start address in sectors |
| len_i | input | 48 | Transfer length in sectors |
| buf_fill_i | input | 16 | Sectors held in the data buffer |
| buf_free_i | input | 16 | Free sectors in the data buffer |
| sub_done_i | input | 1 | Outstanding sub-command finished |
| sub_err_i | input | 1 | Outstanding sub-command failed |
| id_cap_i | input | 48 | Capacity reported by identify |
| id_4k_i | input | 1 | Sector-size mode reported by identify |
| busy_o | output | 1 | Block busy or inactive |
| sub_issue_o | output | 1 | Sub-command strobe, one cycle |
| sub_op_o | output | 3 | Sub-command opcode |
| sub_addr_o | output | 48 | Sub-command start sector |
| sub_cnt_o | output | 9 | Sub-command sector count |
| capacity_o | output | 48 | Captured device capacity |
| lba_4k_o | output | 1 | Captured sector-size mode |

## Verification
A stale remaining-length or address register shows up at the very next strobe as a wrong sub_addr_o or sub_cnt_o, or as an extra or missing strobe before busy_o falls. A wrong state shows as busy_o falling one cycle early, before the read drain or the last done, or as busy_o never falling. A missed terminal state shows the same way, within one cycle, when a request after shutdown or an error still raises a strobe. A gating fault shows as a strobe that appears while the buffer level is still short, which the bench checks over a window of idle cycles.

// File: rtl/stor_cmd_pkg.sv
package stor_cmd_pkg;
  typedef enum logic [2:0] {
    OP_IDENT = 3'b000,
    OP_SHUT  = 3'b001,
    OP_WR    = 3'b010,
    OP_RD    = 3'b011,
    OP_HLOG  = 3'b100,
    OP_RSV5  = 3'b101,
    OP_FLUSH = 3'b110,
    OP_INIT  = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    S_LINK,
    S_IDLE,
    S_GATE,
    S_WAIT,
    S_DRAIN,
    S_FIN,
    S_DEAD
  } st_e;
endpackage

// File: rtl/stor_op_decode.sv
module stor_op_decode
  import stor_cmd_pkg::*;
(
  input  op_e  op_i,
  output logic valid_o,
  output logic xfer_o
);
  always_comb begin
    valid_o = 1'b1;
    xfer_o  = 1'b0;
    unique case (op_i)
      OP_WR, OP_RD:                     xfer_o  = 1'b1;
      OP_IDENT, OP_SHUT, OP_HLOG, OP_FLUSH: xfer_o = 1'b0;
      default:                          valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/stor_chunk_calc.sv
module stor_chunk_calc #(
  parameter int LEN_W     = 48,
  parameter int MAX_CHUNK = 256,
  parameter int CNT_W     = $clog2(MAX_CHUNK + 1)
) (
  input  logic [LEN_W-1:0] rem_i,
  output logic [CNT_W-1:0] chunk_o
);
  localparam logic [LEN_W-1:0] MaxLen = LEN_W'(MAX_CHUNK);

  always_comb begin
    if (rem_i > MaxLen) chunk_o = CNT_W'(MAX_CHUNK);
    else                chunk_o = rem_i[CNT_W-1:0];
  end
endmodule

// File: rtl/stor_level_gate.sv
module stor_level_gate #(
  parameter int LVL_W = 16,
  parameter int CNT_W = 9
) (
  input  logic             rd_i,
  input  logic [LVL_W-1:0] fill_i,
  input  logic [LVL_W-1:0] free_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             ok_o
);
  localparam int W = LVL_W + CNT_W;

  logic [W-1:0] need_x, fill_x, free_x;

  assign need_x = W'(need_i);
  assign fill_x = W'(fill_i);
  assign free_x = W'(free_i);
  // read needs room to land, write needs data on hand
  assign ok_o   = rd_i ? (free_x >= need_x) : (fill_x >= need_x);
endmodule

// File: rtl/stor_cmd_seq.sv
module stor_cmd_seq
  import stor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int LEN_W     = 48,
  parameter int LVL_W     = 16,
  parameter int MAX_CHUNK = 256,
  parameter int CNT_W     = $clog2(MAX_CHUNK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_up_i,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LVL_W-1:0]  buf_fill_i,
  input  logic [LVL_W-1:0]  buf_free_i,
  input  logic              sub_done_i,
  input  logic              sub_err_i,
  input  logic [ADDR_W-1:0] id_cap_i,
  input  logic              id_4k_i,
  output logic              busy_o,
  output logic              sub_issue_o,
  output logic [2:0]        sub_op_o,
  output logic [ADDR_W-1:0] sub_addr_o,
  output logic [CNT_W-1:0]  sub_cnt_o,
  output logic [ADDR_W-1:0] capacity_o,
  output logic              lba_4k_o
);
  st_e               st_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              iss_q;
  logic [ADDR_W-1:0] iss_addr_q;
  logic [CNT_W-1:0]  iss_cnt_q;
  logic [ADDR_W-1:0] cap_q;
  logic              lba4k_q;

  logic              req_valid, req_xfer, gate_ok;
  logic [CNT_W-1:0]  chunk;

  stor_op_decode u_dec (
    .op_i    (op_e'(op_i)),
    .valid_o (req_valid),
    .xfer_o  (req_xfer)
  );

  stor_chunk_calc #(
    .LEN_W     (LEN_W),
    .MAX_CHUNK (MAX_CHUNK),
    .CNT_W     (CNT_W)
  ) u_chunk (
    .rem_i   (rem_q),
    .chunk_o (chunk)
  );

  stor_level_gate #(
    .LVL_W (LVL_W),
    .CNT_W (CNT_W)
  ) u_gate (
    .rd_i   (op_q == OP_RD),
    .fill_i (buf_fill_i),
    .free_i (buf_free_i),
    .need_i (chunk),
    .ok_o   (gate_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_LINK;
      op_q       <= OP_INIT;
      addr_q     <= '0;
      rem_q      <= '0;
      iss_q      <= 1'b0;
      iss_addr_q <= '0;
      iss_cnt_q  <= '0;
      cap_q      <= '0;
      lba4k_q    <= 1'b0;
    end else begin
      iss_q <= 1'b0;
      unique case (st_q)
        S_LINK: begin
          if (link_up_i) begin
            iss_q      <= 1'b1;
            op_q       <= OP_INIT;
            iss_addr_q <= '0;
            iss_cnt_q  <= '0;
            st_q       <= S_WAIT;
          end
        end
        S_IDLE: begin
          if (req_i && req_valid) begin
            op_q   <= op_e'(op_i);
            addr_q <= addr_i;
            rem_q  <= len_i;
            if (req_xfer) begin
              st_q <= (len_i == '0) ? S_FIN : S_GATE;
            end else begin
              iss_q      <= 1'b1;
              iss_addr_q <= addr_i;
              iss_cnt_q  <= '0;
              st_q       <= S_WAIT;
            end
          end
        end
        S_GATE: begin
          if (gate_ok) begin
            iss_q      <= 1'b1;
            iss_addr_q <= addr_q;
            iss_cnt_q  <= chunk;
            addr_q     <= addr_q + ADDR_W'(chunk);
            rem_q      <= rem_q - LEN_W'(chunk);
            st_q       <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (sub_err_i) begin
            st_q <= S_DEAD;
          end else if (sub_done_i) begin
            unique case (op_q)
              OP_SHUT: st_q <= S_DEAD;
              OP_IDENT: begin
                cap_q   <= id_cap_i;
                lba4k_q <= id_4k_i;
                st_q    <= S_IDLE;
              end
              OP_WR:   st_q <= (rem_q == '0) ? S_IDLE  : S_GATE;
              OP_RD:   st_q <= (rem_q == '0) ? S_DRAIN : S_GATE;
              default: st_q <= S_IDLE;
            endcase
          end
        end
        S_DRAIN: if (buf_fill_i == '0) st_q <= S_IDLE;
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_DEAD;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign sub_issue_o = iss_q;
  assign sub_op_o    = op_q;
  assign sub_addr_o  = iss_addr_q;
  assign sub_cnt_o   = iss_cnt_q;
  assign capacity_o  = cap_q;
  assign lba_4k_o    = lba4k_q;
endmodule

// File: rtl/stor_cmd_seq_chk.sv
module stor_cmd_seq_chk #(
  parameter int ADDR_W    = 48,
  parameter int LVL_W     = 16,
  parameter int MAX_CHUNK = 256,
  parameter int CNT_W     = $clog2(MAX_CHUNK + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              link_up_i,
  input logic              req_i,
  input logic [2:0]        op_i,
  input logic [LVL_W-1:0]  buf_fill_i,
  input logic [LVL_W-1:0]  buf_free_i,
  input logic              sub_done_i,
  input logic              sub_err_i,
  input logic              busy_o,
  input logic              sub_issue_o,
  input logic [2:0]        sub_op_o,
  input logic [CNT_W-1:0]  sub_cnt_o,
  input logic [ADDR_W-1:0] capacity_o
);
  logic       link_seen_q, wait_q, locked_q;
  logic [2:0] last_op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_seen_q <= 1'b0;
      wait_q      <= 1'b0;
      locked_q    <= 1'b0;
      last_op_q   <= 3'b111;
    end else begin
      if (link_up_i) link_seen_q <= 1'b1;
      if (sub_issue_o) begin
        wait_q    <= 1'b1;
        last_op_q <= sub_op_o;
      end else if (wait_q && (sub_done_i || sub_err_i)) begin
        wait_q <= 1'b0;
        if (sub_err_i || last_op_q == 3'b001) locked_q <= 1'b1;
      end
    end
  end

  a_r2_link_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_seen_q |-> (busy_o && !sub_issue_o));

  a_r3_issue_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_issue_o |-> busy_o);

  a_r4_rsv_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && (op_i == 3'b101 || op_i == 3'b111)) |=> !busy_o);

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_issue_o |-> (sub_cnt_o <= CNT_W'(MAX_CHUNK)));

  a_r5_xfer_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_issue_o && (sub_op_o == 3'b010 || sub_op_o == 3'b011)) |-> (sub_cnt_o != '0));

  a_r5_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_issue_o |=> !sub_issue_o);

  a_r6_write_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_issue_o && sub_op_o == 3'b010) |-> ($past(buf_fill_i) >= LVL_W'(sub_cnt_o)));

  a_r7_read_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_issue_o && sub_op_o == 3'b011) |-> ($past(buf_free_i) >= LVL_W'(sub_cnt_o)));

  a_r9_cap_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(capacity_o) |-> $past(sub_done_i));

  a_r10_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |-> (busy_o && !sub_issue_o));
endmodule

bind stor_cmd_seq stor_cmd_seq_chk #(
  .ADDR_W    (ADDR_W),
  .LVL_W     (LVL_W),
  .MAX_CHUNK (MAX_CHUNK),
  .CNT_W     (CNT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .link_up_i  (link_up_i),
  .req_i      (req_i),
  .op_i       (op_i),
  .buf_fill_i (buf_fill_i),
  .buf_free_i (buf_free_i),
  .sub_done_i (sub_done_i),
  .sub_err_i  (sub_err_i),
  .busy_o     (busy_o),
  .sub_issue_o(sub_issue_o),
  .sub_op_o   (sub_op_o),
  .sub_cnt_o  (sub_cnt_o),
  .capacity_o (capacity_o)
);

// File: tb/stor_cmd_seq_tb.sv
module stor_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        link_up_i = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  op_i = 3'b0;
  logic [47:0] addr_i = '0;
  logic [47:0] len_i = '0;
  logic [15:0] buf_fill_i = '0;
  logic [15:0] buf_free_i = '0;
  logic        sub_done_i = 1'b0;
  logic        sub_err_i = 1'b0;
  logic [47:0] id_cap_i = '0;
  logic        id_4k_i = 1'b0;
  logic        busy_o, sub_issue_o, lba_4k_o;
  logic [2:0]  sub_op_o;
  logic [47:0] sub_addr_o, capacity_o;
  logic [8:0]  sub_cnt_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  stor_cmd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .link_up_i(link_up_i), .req_i(req_i),
    .op_i(op_i), .addr_i(addr_i), .len_i(len_i), .buf_fill_i(buf_fill_i),
    .buf_free_i(buf_free_i), .sub_done_i(sub_done_i), .sub_err_i(sub_err_i),
    .id_cap_i(id_cap_i), .id_4k_i(id_4k_i), .busy_o(busy_o),
    .sub_issue_o(sub_issue_o), .sub_op_o(sub_op_o), .sub_addr_o(sub_addr_o),
    .sub_cnt_o(sub_cnt_o), .capacity_o(capacity_o), .lba_4k_o(lba_4k_o)
  );

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_cnt(input logic [47:0] len, input int k);
    logic [47:0] rem;
    rem = len - 48'(256 * k);
    return (rem > 48'd256) ? 9'd256 : rem[8:0];
  endfunction

  task automatic wait_issue(output bit got);
    got = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (sub_issue_o) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic pulse_done();
    sub_done_i = 1'b1;
    @(negedge clk);
    sub_done_i = 1'b0;
  endtask

  task automatic pulse_err();
    sub_err_i = 1'b1;
    @(negedge clk);
    sub_err_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; link_up_i = 1'b0; req_i = 1'b0;
    sub_done_i = 1'b0; sub_err_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic bring_up(input bit fail_init);
    bit got;
    repeat (4) @(negedge clk);
    check_eq("R2 busy before link", busy_o, 1);
    check_eq("R2 no issue before link", sub_issue_o, 0);
    link_up_i = 1'b1;
    wait_issue(got);
    check_eq("R2 init issued", got, 1);
    check_eq("R2 init op", sub_op_o, 3'b111);
    if (fail_init) begin
      pulse_err();
    end else begin
      @(negedge clk);
      check_eq("R2 busy during init", busy_o, 1);
      pulse_done();
      check_eq("R2 idle after init", busy_o, 0);
    end
  endtask

  task automatic send_req(input logic [2:0] op, input logic [47:0] a, input logic [47:0] l);
    op_i = op; addr_i = a; len_i = l; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic run_xfer(input logic [2:0] op, input logic [47:0] a, input logic [47:0] l);
    bit got;
    int n;
    n = int'((l + 48'd255) / 48'd256);
    if (op == 3'b011) buf_fill_i = 16'd7;
    send_req(op, a, l);
    check_eq("R3 busy after req", busy_o, 1);
    for (int k = 0; k < n; k++) begin
      wait_issue(got);
      check_eq("R5 chunk issued", got, 1);
      check_eq("R5 chunk op", sub_op_o, op);
      check_eq("R5 chunk addr", sub_addr_o, a + 48'(256 * k));
      check_eq("R5 chunk cnt", sub_cnt_o, exp_cnt(l, k));
      pulse_done();
      if (k < n - 1) check_eq("R3 busy mid xfer", busy_o, 1);
    end
    if (op == 3'b011) begin
      repeat (3) @(negedge clk);
      check_eq("R7 busy while draining", busy_o, 1);
      buf_fill_i = 16'd0;
      @(negedge clk);
      check_eq("R7 idle after drain", busy_o, 0);
      buf_fill_i = 16'hFFFF;
    end else begin
      check_eq("R6 idle after last write", busy_o, 0);
    end
  endtask

  task automatic run_simple(input logic [2:0] op, input logic [47:0] a);
    bit got;
    send_req(op, a, 48'd999);
    check_eq("R3 busy after simple req", busy_o, 1);
    wait_issue(got);
    check_eq("R8 simple issued", got, 1);
    check_eq("R8 simple op", sub_op_o, op);
    check_eq("R8 simple addr", sub_addr_o, a);
    check_eq("R8 simple cnt", sub_cnt_o, 0);
    pulse_done();
  endtask

  task automatic expect_no_issue(input string tag, input int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      if (sub_issue_o) seen++;
      @(negedge clk);
    end
    check_eq(tag, seen, 0);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit got;
    void'($urandom(32'd20251));
    buf_fill_i = 16'hFFFF; buf_free_i = 16'hFFFF;
    // R1 reset state
    @(negedge clk);
    check_eq("R1 busy in reset", busy_o, 1);
    check_eq("R1 issue in reset", sub_issue_o, 0);
    do_reset();
    check_eq("R1 busy after reset", busy_o, 1);
    check_eq("R1 capacity reset", capacity_o, 0);
    check_eq("R1 mode reset", lba_4k_o, 0);
    bring_up(1'b0);

    // R9 identify capture
    id_cap_i = 48'h1234_5678_9ABC; id_4k_i = 1'b1;
    run_simple(3'b000, 48'h0);
    check_eq("R9 capacity", capacity_o, 48'h1234_5678_9ABC);
    check_eq("R9 mode", lba_4k_o, 1);
    check_eq("R3 idle after identify", busy_o, 0);
    id_cap_i = 48'h0; id_4k_i = 1'b0;
    run_simple(3'b110, 48'h55);
    run_simple(3'b100, 48'h0);
    check_eq("R9 capacity kept", capacity_o, 48'h1234_5678_9ABC);
    check_eq("R9 mode kept", lba_4k_o, 1);

    // R4 reserved opcodes
    op_i = 3'b101; req_i = 1'b1;
    expect_no_issue("R4 op 101 no issue", 4);
    check_eq("R4 op 101 busy low", busy_o, 0);
    op_i = 3'b111;
    expect_no_issue("R4 op 111 no issue", 4);
    check_eq("R4 op 111 busy low", busy_o, 0);
    req_i = 1'b0;

    // R11 zero length
    send_req(3'b010, 48'h10, 48'd0);
    check_eq("R11 busy one cycle", busy_o, 1);
    expect_no_issue("R11 no issue", 1);
    check_eq("R11 idle", busy_o, 0);
    send_req(3'b011, 48'h10, 48'd0);
    expect_no_issue("R11 read no issue", 1);
    check_eq("R11 read idle", busy_o, 0);

    // R5 boundaries
    run_xfer(3'b010, 48'h100, 48'd256);
    run_xfer(3'b010, 48'h200, 48'd257);
    run_xfer(3'b011, 48'hFFFF_FFFF_FF00, 48'd1);
    run_xfer(3'b011, 48'h300, 48'd512);

    // R6 write gating
    buf_fill_i = 16'd100;
    send_req(3'b010, 48'h1000, 48'd300);
    expect_no_issue("R6 write held short", 20);
    buf_fill_i = 16'd256;
    wait_issue(got);
    check_eq("R6 write released", got, 1);
    check_eq("R6 first cnt", sub_cnt_o, 256);
    buf_fill_i = 16'd43;
    pulse_done();
    expect_no_issue("R6 tail held", 10);
    buf_fill_i = 16'd44;
    wait_issue(got);
    check_eq("R6 tail cnt", sub_cnt_o, 44);
    check_eq("R6 tail addr", sub_addr_o, 48'h1100);
    pulse_done();
    check_eq("R6 idle", busy_o, 0);

    // R7 read gating
    buf_fill_i = 16'd0; buf_free_i = 16'd10;
    send_req(3'b011, 48'h2000, 48'd20);
    expect_no_issue("R7 read held no room", 20);
    buf_free_i = 16'd20;
    wait_issue(got);
    check_eq("R7 read released", got, 1);
    check_eq("R7 read cnt", sub_cnt_o, 20);
    pulse_done();
    check_eq("R7 drain cycle busy", busy_o, 1);
    @(negedge clk);
    check_eq("R7 idle when empty", busy_o, 0);
    buf_fill_i = 16'hFFFF; buf_free_i = 16'hFFFF;

    // random transfers
    for (int t = 0; t < 24; t++) begin
      logic [47:0] ra, rl;
      ra = {$urandom(), $urandom()} & 48'h0000_FFFF_FFFF;
      rl = 48'($urandom_range(1, 1100));
      run_xfer(($urandom_range(0, 1) != 0) ? 3'b011 : 3'b010, ra, rl);
    end

    // R10 shutdown lock
    run_simple(3'b001, 48'h0);
    check_eq("R10 busy after shutdown", busy_o, 1);
    send_req(3'b010, 48'h0, 48'd8);
    expect_no_issue("R10 no issue after shutdown", 10);
    check_eq("R10 still busy", busy_o, 1);

    // R12 error during transfer
    do_reset();
    bring_up(1'b0);
    send_req(3'b010, 48'h0, 48'd600);
    wait_issue(got);
    pulse_err();
    expect_no_issue("R12 no issue after error", 10);
    check_eq("R12 busy after error", busy_o, 1);
    send_req(3'b000, 48'h0, 48'd0);
    expect_no_issue("R12 request blocked", 5);
    check_eq("R12 busy held", busy_o, 1);

    // R2 init error
    do_reset();
    bring_up(1'b1);
    expect_no_issue("R2 dead after init error", 10);
    check_eq("R2 busy after init error", busy_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule